// File: doc/BRIEF.md
# Read-Cycle Four-Phase Handshake Controller

This block runs the read cycle between a bus master and a slow local device as a four-phase, return-to-zero handshake. The bus raises a request. The controller strobes the device and waits for the device acknowledge. It then opens the data latch and only after that acknowledges the bus. When the bus drops its request, the controller closes the latch first. It then lowers the bus acknowledge and the device strobe, which may fall together. Before it accepts another request, it waits for the device acknowledge to return low.

The controller is a clocked state machine. Its inputs must already be synchronized to `clk_i`. Each output register changes on the clock edge after the input that enables it is sampled. Two states of the return phase look the same on every handshake wire as states of the forward phase. An internal return-phase bit separates them, so that a request that arrives early is held off.

A parameter selects how the device strobe is held. In one form it is held by the request OR the latch enable, so it falls one edge after the latch closes. In the other form it simply follows the request. A sticky error output reports an input that changes out of order.

Top module: `rd_hs_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, all four outputs are low.
- R2: The controller must be idle, with the device acknowledge low and the request sampled high. In that state, `dev_strobe_o` rises at the next clock edge.
- R3: `latch_en_o` rises one edge after `dev_ack_i` is sampled high while the strobe is high. It stays low for as long as `dev_ack_i` is low.
- R4: `xfer_ack_o` rises exactly one edge after `latch_en_o` rises and never before it. It then holds while the request stays high.
- R5: With `xfer_ack_o` high, a low request makes `latch_en_o` fall at the next edge. `xfer_ack_o` stays high at that edge.
- R6: `xfer_ack_o` falls one edge after `latch_en_o` falls.
- R7: With `STROBE_HOLD_OR`=1, `dev_strobe_o` falls at the same edge as `xfer_ack_o`. With `STROBE_HOLD_OR`=0, it falls at the same edge as `latch_en_o`.
- R8: A request that rises while `dev_ack_i` is high is not served, and the strobe stays low. Once `dev_ack_i` is sampled low, the strobe rises two edges later: one edge clears the return-phase bit and the next edge starts the cycle.
- R9: `proto_err_o` is set at the edge after any of these input events:
  - `dev_ack_i` rises while the strobe is low.
  - `dev_ack_i` falls while the strobe is high.
  - The request falls while `xfer_ack_o` is low.
  - The request rises while `dev_ack_i` is high.
- R10: `proto_err_o` stays high until reset and is low after reset.
- R11: A legal cycle ends with all outputs low and no error. A request raised in the same sample that `dev_ack_i` returns low is served, and the strobe rises two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request from the bus (synchronized) |
| dev_ack_i | input | 1 | Acknowledge from the local device (synchronized) |
| dev_strobe_o | output | 1 | Strobe to the local device |
| latch_en_o | output | 1 | Data latch enable |
| xfer_ack_o | output | 1 | Transfer acknowledge to the bus |
| proto_err_o | output | 1 | Sticky protocol-violation flag |

## Verification
The bench sweeps device latency against request hold time on both strobe variants at once. It checks every output edge at its exact cycle. A design that raised the bus acknowledge alongside the latch, or that let the strobe outlive or undercut the latch in the wrong variant, would show a one-cycle mismatch there. Early re-requests probe the return-phase bit. Without that bit, the controller would restart while the device still acknowledges and would strobe one cycle too soon after a back-to-back request. Each violation kind is injected on its own, to catch an error flag that misses a case or that clears itself.

// File: rtl/rd_hs_pkg.sv
package rd_hs_pkg;

  // handshake events decoded each cycle
  typedef struct packed {
    logic start;      // request accepted, strobe goes up
    logic latch_up;
    logic ack_up;
    logic rtz_enter;  // latch closes, return phase begins
    logic ack_down;
    logic rtz_exit;   // cycle complete
  } hs_evt_t;

endpackage

// File: rtl/rd_hs_seq.sv
module rd_hs_seq
  import rd_hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic dev_ack_i,
  input  logic strobe_i,
  output logic start_o,
  output logic latch_o,
  output logic ack_o,
  output logic rtz_o
);

  hs_evt_t evt;
  logic latch_q, ack_q, rtz_q;

  always_comb begin
    evt.start     = !rtz_q && !strobe_i && !latch_q && !ack_q && req_i && !dev_ack_i;
    evt.latch_up  = !rtz_q && strobe_i && dev_ack_i && req_i && !latch_q && !ack_q;
    evt.ack_up    = !rtz_q && latch_q && !ack_q;
    evt.rtz_enter = !rtz_q && latch_q && ack_q && !req_i;
    evt.ack_down  = rtz_q && ack_q && !latch_q;
    evt.rtz_exit  = rtz_q && !ack_q && !latch_q && !strobe_i && !dev_ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      ack_q   <= 1'b0;
      rtz_q   <= 1'b0;
    end else begin
      if (evt.latch_up)       latch_q <= 1'b1;
      else if (evt.rtz_enter) latch_q <= 1'b0;

      if (evt.ack_up)         ack_q <= 1'b1;
      else if (evt.ack_down)  ack_q <= 1'b0;

      if (evt.rtz_enter)      rtz_q <= 1'b1;
      else if (evt.rtz_exit)  rtz_q <= 1'b0;
    end
  end

  assign start_o = evt.start;
  assign latch_o = latch_q;
  assign ack_o   = ack_q;
  assign rtz_o   = rtz_q;

endmodule

// File: rtl/rd_hs_strobe.sv
module rd_hs_strobe #(
  parameter bit HOLD_OR = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic latch_i,
  input  logic rtz_i,
  input  logic start_i,
  output logic strobe_o
);

  logic keep_c, strobe_q;

  generate
    if (HOLD_OR) begin : g_hold_or
      // held by request or latch: safe without a latch-before-strobe guarantee
      assign keep_c = (req_i && !rtz_i) || latch_i;
    end else begin : g_follow
      // follows request: relies on latch closing no later than strobe
      assign keep_c = req_i && !rtz_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= keep_c && (strobe_q || start_i);
  end

  assign strobe_o = strobe_q;

endmodule

// File: rtl/rd_hs_guard.sv
module rd_hs_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic dev_ack_i,
  input  logic strobe_i,
  input  logic ack_i,
  output logic err_o
);

  logic req_p, dack_p, err_q, viol_c;

  always_comb begin
    viol_c = ( dev_ack_i && !dack_p && !strobe_i)
          || (!dev_ack_i &&  dack_p &&  strobe_i)
          || (!req_i     &&  req_p  && !ack_i)
          || ( req_i     && !req_p  &&  dev_ack_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_p  <= 1'b0;
      dack_p <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      req_p  <= req_i;
      dack_p <= dev_ack_i;
      err_q  <= err_q || viol_c;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/rd_hs_ctrl.sv
module rd_hs_ctrl #(
  parameter bit STROBE_HOLD_OR = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic dev_ack_i,
  output logic dev_strobe_o,
  output logic latch_en_o,
  output logic xfer_ack_o,
  output logic proto_err_o
);

  logic start, latch, ack, rtz, strobe;

  rd_hs_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .dev_ack_i (dev_ack_i),
    .strobe_i  (strobe),
    .start_o   (start),
    .latch_o   (latch),
    .ack_o     (ack),
    .rtz_o     (rtz)
  );

  rd_hs_strobe #(.HOLD_OR(STROBE_HOLD_OR)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .latch_i  (latch),
    .rtz_i    (rtz),
    .start_i  (start),
    .strobe_o (strobe)
  );

  rd_hs_guard u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .dev_ack_i (dev_ack_i),
    .strobe_i  (strobe),
    .ack_i     (ack),
    .err_o     (proto_err_o)
  );

  assign dev_strobe_o = strobe;
  assign latch_en_o   = latch;
  assign xfer_ack_o   = ack;

endmodule

// File: rtl/rd_hs_ctrl_chk.sv
module rd_hs_ctrl_chk #(
  parameter bit STROBE_HOLD_OR = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic dev_ack_i,
  input logic dev_strobe_o,
  input logic latch_en_o,
  input logic xfer_ack_o,
  input logic proto_err_o
);

  a_r2_strobe_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_strobe_o) |-> $past(req_i) && !$past(dev_ack_i));

  a_r3_latch_needs_dev_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_en_o) |-> $past(dev_ack_i) && $past(dev_strobe_o));

  a_r4_ack_after_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_ack_o) |-> $past(latch_en_o));

  a_r5_latch_close_on_req_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_en_o) |-> !$past(req_i) && xfer_ack_o);

  a_r6_ack_drop_after_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xfer_ack_o) |-> !$past(latch_en_o));

  generate
    if (STROBE_HOLD_OR) begin : g_or
      a_r7_strobe_outlives_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(latch_en_o) |-> dev_strobe_o);
      a_r7_strobe_drop_latch_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dev_strobe_o) |-> !$past(latch_en_o));
    end else begin : g_follow
      a_r7_strobe_with_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(latch_en_o) |-> !dev_strobe_o);
    end
  endgenerate

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);

endmodule

bind rd_hs_ctrl rd_hs_ctrl_chk #(.STROBE_HOLD_OR(STROBE_HOLD_OR)) u_rd_hs_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .dev_ack_i    (dev_ack_i),
  .dev_strobe_o (dev_strobe_o),
  .latch_en_o   (latch_en_o),
  .xfer_ack_o   (xfer_ack_o),
  .proto_err_o  (proto_err_o)
);

// File: tb/rd_hs_ctrl_bench.sv
module rd_hs_ctrl_bench;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0;
  logic dack = 1'b0;
  logic or_stb, or_lat, or_ack, or_err;
  logic fo_stb, fo_lat, fo_ack, fo_err;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rd_hs_ctrl #(.STROBE_HOLD_OR(1'b1)) u_rd_hs_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .dev_ack_i(dack),
    .dev_strobe_o(or_stb), .latch_en_o(or_lat), .xfer_ack_o(or_ack), .proto_err_o(or_err)
  );

  rd_hs_ctrl #(.STROBE_HOLD_OR(1'b0)) u_rd_hs_ctrl_follow (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .dev_ack_i(dack),
    .dev_strobe_o(fo_stb), .latch_en_o(fo_lat), .xfer_ack_o(fo_ack), .proto_err_o(fo_err)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_state(input string tag, input logic s_or, input logic s_fo,
                           input logic lat, input logic ack, input logic err);
    chk(tag, "or.strobe", or_stb, s_or);
    chk(tag, "fo.strobe", fo_stb, s_fo);
    chk(tag, "or.latch",  or_lat, lat);
    chk(tag, "fo.latch",  fo_lat, lat);
    chk(tag, "or.ack",    or_ack, ack);
    chk(tag, "fo.ack",    fo_ack, ack);
    chk(tag, "or.err",    or_err, err);
    chk(tag, "fo.err",    fo_err, err);
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_ni = 1'b0; req = 1'b0; dack = 1'b0;
    tick; tick;
    rst_ni = 1'b1;
    tick;
  endtask

  // one legal read; device acknowledges lat edges after strobe
  task automatic run_cycle(input int lat, input int hold, input bit pre, input bit chain);
    if (!pre) begin
      req = 1'b1; tick;
      chk_state("R2", 1, 1, 0, 0, 0);
    end
    for (int i = 1; i < lat; i++) begin
      tick;
      chk_state("R3", 1, 1, 0, 0, 0);
    end
    dack = 1'b1; tick;
    chk_state("R3", 1, 1, 1, 0, 0);
    tick;
    chk_state("R4", 1, 1, 1, 1, 0);
    for (int i = 0; i < hold; i++) begin
      tick;
      chk_state("R4", 1, 1, 1, 1, 0);
    end
    req = 1'b0; tick;
    chk_state("R5/R7", 1, 0, 0, 1, 0);
    tick;
    chk_state("R6/R7", 0, 0, 0, 0, 0);
    dack = 1'b0;
    if (chain) req = 1'b1;
    tick;
    chk_state("R11", 0, 0, 0, 0, 0);
    tick;
    if (chain) chk_state("R11", 1, 1, 0, 0, 0);
    else       chk_state("R11", 0, 0, 0, 0, 0);
  endtask

  initial begin
    bit prev_chain;
    bit ch;
    prev_chain = 1'b0;
    tick;
    chk_state("R1", 0, 0, 0, 0, 0);
    rst_ni = 1'b1;
    tick; tick;
    chk_state("R1", 0, 0, 0, 0, 0);

    // sweep device latency against request hold
    for (int lat = 1; lat <= 4; lat++) begin
      for (int hold = 0; hold <= 3; hold++) begin
        ch = (hold == 2);
        run_cycle(lat, hold, prev_chain, ch);
        prev_chain = ch;
      end
    end

    // early request during return phase
    req = 1'b1; tick;
    dack = 1'b1; tick; tick;
    req = 1'b0; tick; tick;
    chk_state("R8", 0, 0, 0, 0, 0);
    req = 1'b1; tick;
    chk_state("R8/R9", 0, 0, 0, 0, 1);
    tick; tick;
    chk_state("R8", 0, 0, 0, 0, 1);
    dack = 1'b0; tick;
    chk_state("R8", 0, 0, 0, 0, 1);
    tick;
    chk_state("R8/R10", 1, 1, 0, 0, 1);
    do_reset;
    chk_state("R10", 0, 0, 0, 0, 0);

    // device acknowledge without strobe
    dack = 1'b1; tick;
    chk_state("R9", 0, 0, 0, 0, 1);
    dack = 1'b0; tick; tick; tick;
    chk("R10", "or.err held", or_err, 1'b1);
    chk("R10", "fo.err held", fo_err, 1'b1);
    do_reset;
    chk_state("R10", 0, 0, 0, 0, 0);

    // request withdrawn before bus acknowledge
    req = 1'b1; tick;
    req = 1'b0; tick;
    chk("R9", "or.err req drop", or_err, 1'b1);
    chk("R9", "fo.err req drop", fo_err, 1'b1);
    do_reset;

    // device acknowledge dropped while strobe high
    req = 1'b1; tick;
    dack = 1'b1; tick;
    chk_state("R3", 1, 1, 1, 0, 0);
    dack = 1'b0; tick;
    chk("R9", "or.err dack drop", or_err, 1'b1);
    chk("R9", "fo.err dack drop", fo_err, 1'b1);
    do_reset;
    chk_state("R1", 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule